// File: doc/BRIEF.md
# Iterative Multiply-Accumulate Engine

This block multiplies two 32-bit operands with one radix-2 shift-and-add engine. The same engine serves six operations: short and long forms, signed and unsigned, with or without an accumulated addend. The short forms keep only the lower product word. The long forms return the whole 64-bit result as a high word and a low word. A signed long product is formed from the operand magnitudes and negated when the operand signs differ. The addend is added only after that negation.

A client raises `start` for one cycle while `busy` is low. It presents the operation code, both operands and the accumulator words in that same cycle. The block copies all of these into its own registers, runs one multiplier bit per cycle and pulses `done` once when the result is ready. The result stays on `res_hi`/`res_lo` until the next operation completes.

The controller has five states:
- ST_IDLE waits for `start`.
- ST_PREP loads the magnitudes into the engine.
- ST_ITER runs 32 add-and-shift steps.
- ST_FINISH applies the sign and the addend and registers the result.
- ST_DONE pulses `done`.

The transitions are named as follows:
- accept: ST_IDLE or ST_DONE to ST_PREP, on `start`.
- load: ST_PREP to ST_ITER.
- last_step: ST_ITER to ST_FINISH, after step 32.
- commit: ST_FINISH to ST_DONE.
- release: ST_DONE to ST_IDLE, when `start` is low.

Top module: `mac_engine`

## Requirements
- R1: After reset `busy` and `done` are 0 and `res_hi`/`res_lo` are 0.
- R2: Op code 0 (and the unused codes 6 and 7) gives `res_lo` = low 32 bits of opa×opb and `res_hi` = 0, whether the operands are read as signed or unsigned.
- R3: Op code 1 gives `res_lo` = low 32 bits of opa×opb + `acc_lo` and `res_hi` = 0; `acc_hi` is not used.
- R4: Op code 2 gives {`res_hi`,`res_lo`} = the unsigned 64-bit product of opa and opb.
- R5: Op code 3 gives {`res_hi`,`res_lo`} = unsigned opa×opb + {`acc_hi`,`acc_lo`}, modulo 2^64.
- R6: Op code 4 gives {`res_hi`,`res_lo`} = the two's-complement 64-bit product of opa and opb read as signed.
- R7: Op code 5 gives {`res_hi`,`res_lo`} = signed opa×opb + {`acc_hi`,`acc_lo`}, modulo 2^64.
- R8: `start` is accepted only while `busy` is 0. Op code, operands and accumulator words are latched in the accepting cycle, and later changes on those inputs do not alter the result.
- R9: A `start` pulse while `busy` is 1 is ignored: the running operation is not restarted and its result is unchanged.
- R10: `busy` rises on the clock edge that accepts `start` and stays high for 34 cycles. `done` is high for exactly one cycle, on the 34th edge after acceptance, and `busy` is low while `done` is high.
- R11: `res_hi`/`res_lo` change only on the edge that raises `done` and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new operation |
| op | input | 3 | Operation code (0..5, see requirements) |
| opa | input | 32 | Multiplicand |
| opb | input | 32 | Multiplier |
| acc_hi | input | 32 | Upper accumulator word (long accumulate only) |
| acc_lo | input | 32 | Lower accumulator word / short addend |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| res_hi | output | 32 | Upper result word (0 for short forms) |
| res_lo | output | 32 | Lower result word |

## Verification
Directed operands cover the extremes that separate the signed and unsigned paths: the most negative value squared, all-ones times all-ones, and mixed signs. They also cover zero and one, and accumulators that force wrap-around past 2^32 and 2^64. These show whether negation is applied before accumulation and whether short forms really drop the upper word. Random operands and op codes over all eight codes compare every result with a 64-bit arithmetic model. Inputs are scrambled right after acceptance and `start` is pulsed mid-run, which separates correct latching and ignoring from a design that samples live inputs or restarts.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [2:0] {
        OP_MUL   = 3'd0,
        OP_MLA   = 3'd1,
        OP_UMULL = 3'd2,
        OP_UMLAL = 3'd3,
        OP_SMULL = 3'd4,
        OP_SMLAL = 3'd5
    } mac_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_ITER,
        ST_FINISH,
        ST_DONE
    } mac_state_e;

    function automatic logic op_is_long(input logic [2:0] code);
        return (code == OP_UMULL) || (code == OP_UMLAL) ||
               (code == OP_SMULL) || (code == OP_SMLAL);
    endfunction

    function automatic logic op_is_signed(input logic [2:0] code);
        return (code == OP_SMULL) || (code == OP_SMLAL);
    endfunction

    function automatic logic op_is_accum(input logic [2:0] code);
        return (code == OP_MLA) || (code == OP_UMLAL) || (code == OP_SMLAL);
    endfunction

endpackage

// File: rtl/mac_operand_prep.sv
module mac_operand_prep #(
    parameter int DATA_W = 32
) (
    input  logic              signed_mode,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] a_mag,
    output logic [DATA_W-1:0] b_mag,
    output logic              negate
);
    logic a_neg;
    logic b_neg;

    always_comb begin
        a_neg  = signed_mode & a_in[DATA_W-1];
        b_neg  = signed_mode & b_in[DATA_W-1];
        a_mag  = a_neg ? (~a_in + 1'b1) : a_in;
        b_mag  = b_neg ? (~b_in + 1'b1) : b_in;
        negate = a_neg ^ b_neg;
    end
endmodule

// File: rtl/mac_shift_add.sv
module mac_shift_add #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                step,
    input  logic [DATA_W-1:0]   mcand,
    input  logic [DATA_W-1:0]   mplier,
    output logic [2*DATA_W-1:0] prod
);
    localparam int PROD_W = 2 * DATA_W;

    logic [PROD_W-1:0] mc_q;
    logic [DATA_W-1:0] mp_q;
    logic [PROD_W-1:0] prod_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mc_q   <= '0;
            mp_q   <= '0;
            prod_q <= '0;
        end else if (load) begin
            mc_q   <= {{DATA_W{1'b0}}, mcand};
            mp_q   <= mplier;
            prod_q <= '0;
        end else if (step) begin
            if (mp_q[0]) begin
                prod_q <= prod_q + mc_q;
            end
            mc_q <= mc_q << 1;
            mp_q <= mp_q >> 1;
        end
    end

    assign prod = prod_q;
endmodule

// File: rtl/mac_finish.sv
module mac_finish #(
    parameter int DATA_W = 32
) (
    input  logic [2*DATA_W-1:0] prod,
    input  logic                negate,
    input  logic                long_form,
    input  logic                accum,
    input  logic [DATA_W-1:0]   add_hi,
    input  logic [DATA_W-1:0]   add_lo,
    output logic [2*DATA_W-1:0] result
);
    localparam int PROD_W = 2 * DATA_W;

    logic [PROD_W-1:0] signed_prod;
    logic [PROD_W-1:0] addend;
    logic [PROD_W-1:0] total;

    always_comb begin
        signed_prod = negate ? (~prod + 1'b1) : prod;
        if (!accum) begin
            addend = '0;
        end else if (long_form) begin
            addend = {add_hi, add_lo};
        end else begin
            addend = {{DATA_W{1'b0}}, add_lo};
        end
        total = signed_prod + addend;
        if (long_form) begin
            result = total;
        end else begin
            result = {{DATA_W{1'b0}}, total[DATA_W-1:0]};
        end
    end
endmodule

// File: rtl/mac_engine.sv
module mac_engine #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] acc_hi,
    input  logic [DATA_W-1:0] acc_lo,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] res_hi,
    output logic [DATA_W-1:0] res_lo
);
    import mac_pkg::*;

    localparam int PROD_W = 2 * DATA_W;
    localparam int CNT_W  = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

    mac_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [2:0]        op_q;
    logic [DATA_W-1:0] a_q, b_q, hi_q, lo_q;
    logic [PROD_W-1:0] res_q;

    logic              accept;
    logic              load;
    logic              step;
    logic [DATA_W-1:0] a_mag, b_mag;
    logic              negate;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] fin_res;

    assign accept = start && !busy;

    // State register, step counter and input latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            op_q    <= '0;
            a_q     <= '0;
            b_q     <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q <= op;
                a_q  <= opa;
                b_q  <= opb;
                hi_q <= acc_hi;
                lo_q <= acc_lo;
            end
            if (load) begin
                cnt_q <= '0;
            end else if (step) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Result register, written once per operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (state_q == ST_FINISH) begin
            res_q <= fin_res;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_PREP;
            ST_PREP:   state_d = ST_ITER;
            ST_ITER:   if (cnt_q == LAST_STEP) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_DONE;
            ST_DONE:   state_d = start ? ST_PREP : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        load = 1'b0;
        step = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_PREP:   begin busy = 1'b1; load = 1'b1; end
            ST_ITER:   begin busy = 1'b1; step = 1'b1; end
            ST_FINISH: busy = 1'b1;
            ST_DONE:   done = 1'b1;
            default:   ;
        endcase
    end

    mac_operand_prep #(.DATA_W(DATA_W)) i_prep (
        .signed_mode (op_is_signed(op_q)),
        .a_in        (a_q),
        .b_in        (b_q),
        .a_mag       (a_mag),
        .b_mag       (b_mag),
        .negate      (negate)
    );

    mac_shift_add #(.DATA_W(DATA_W)) i_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .mcand  (a_mag),
        .mplier (b_mag),
        .prod   (prod)
    );

    mac_finish #(.DATA_W(DATA_W)) i_finish (
        .prod      (prod),
        .negate    (negate),
        .long_form (op_is_long(op_q)),
        .accum     (op_is_accum(op_q)),
        .add_hi    (hi_q),
        .add_lo    (lo_q),
        .result    (fin_res)
    );

    assign res_hi = res_q[PROD_W-1:DATA_W];
    assign res_lo = res_q[DATA_W-1:0];
endmodule

// File: rtl/mac_engine_chk.sv
module mac_engine_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] res_hi,
    input logic [DATA_W-1:0] res_lo,
    input logic [2:0]        op_q
);
    import mac_pkg::*;

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!busy && !done)); // R1

    AST_SHORT_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !op_is_long(op_q)) |-> (res_hi == '0)); // R2

    AST_ACCEPT_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R8

    AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(op_q)); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy)); // R10

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(res_lo) || !$stable(res_hi)) |-> done); // R11
endmodule

bind mac_engine mac_engine_chk #(.DATA_W(DATA_W)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .res_hi (res_hi),
    .res_lo (res_lo),
    .op_q   (op_q)
);

// File: tb/test_mac_engine.sv
module test_mac_engine;
    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] opa = '0, opb = '0, acc_hi = '0, acc_lo = '0;
    logic        busy, done;
    logic [31:0] res_hi, res_lo;

    int checks = 0;
    int failures = 0;
    int unused_seed = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_engine i_mac_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .opa(opa), .opb(opb), .acc_hi(acc_hi), .acc_lo(acc_lo),
        .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo)
    );

    function automatic logic [63:0] model(input logic [2:0] code, input logic [31:0] a,
                                          input logic [31:0] b, input logic [31:0] hi,
                                          input logic [31:0] lo);
        logic [63:0]        u;
        logic signed [63:0] s;
        u = {32'h0, a} * {32'h0, b};
        s = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
        case (code)
            3'd1:    return {32'h0, u[31:0] + lo};
            3'd2:    return u;
            3'd3:    return u + {hi, lo};
            3'd4:    return s;
            3'd5:    return s + {hi, lo};
            default: return {32'h0, u[31:0]};
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] code);
        case (code)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one operation; scramble exercises R8, poke exercises R9.
    task automatic run_op(input logic [2:0] code, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] hi, input logic [31:0] lo, input logic poke);
        logic [63:0] exp;
        logic [63:0] held;
        int cyc;
        exp = model(code, a, b, hi, lo);
        @(negedge clk);
        check64("R8", {63'h0, busy}, 64'h0);
        start = 1'b1; op = code; opa = a; opb = b; acc_hi = hi; acc_lo = lo;
        @(posedge clk);
        cyc = 0;
        @(negedge clk);
        start = 1'b0;
        op = 3'($urandom); opa = $urandom; opb = $urandom; acc_hi = $urandom; acc_lo = $urandom;
        check64("R10", {63'h0, busy}, 64'h1);
        while (!done && cyc < 200) begin
            if (poke && cyc == 5) start = 1'b1;
            else start = 1'b0;
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        check64("R10", 64'(cyc), 64'(LATENCY));
        check64("R10", {63'h0, busy}, 64'h0);
        check64(poke ? "R9" : req_of(code), {res_hi, res_lo}, exp);
        held = {res_hi, res_lo};
        @(negedge clk);
        check64("R10", {63'h0, done}, 64'h0);
        check64("R11", {res_hi, res_lo}, held);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        unused_seed = $urandom(32'd7331);
        repeat (3) @(negedge clk);
        // R1: reset state
        check64("R1", {62'h0, busy, done}, 64'h0);
        check64("R1", {res_hi, res_lo}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check64("R1", {62'h0, busy, done}, 64'h0);

        // Directed corners
        run_op(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0);       // R2
        run_op(3'd0, 32'h8000_0000, 32'h8000_0000, 32'h0, 32'h0, 1'b0);       // R2
        run_op(3'd6, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0, 32'h0, 1'b0);       // R2 unused code
        run_op(3'd7, 32'hDEAD_BEEF, 32'h0000_0003, 32'h1, 32'h1, 1'b0);       // R2 unused code
        run_op(3'd1, 32'hFFFF_FFFF, 32'h0000_0002, 32'hFFFF_FFFF, 32'h5, 1'b0); // R3 wrap
        run_op(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0);       // R4
        run_op(3'd2, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0);               // R4 zero
        run_op(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0); // R5 wrap
        run_op(3'd4, 32'h8000_0000, 32'h8000_0000, 32'h0, 32'h0, 1'b0);       // R6
        run_op(3'd4, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 32'h0, 1'b0);       // R6
        run_op(3'd4, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0, 32'h0, 1'b0);       // R6
        run_op(3'd5, 32'hFFFF_FFFB, 32'h0000_0004, 32'h0000_0000, 32'h0000_0015, 1'b0); // R7
        run_op(3'd5, 32'h0000_0003, 32'h0000_0007, 32'hFFFF_FFFF, 32'hFFFF_FFF0, 1'b0); // R7
        run_op(3'd3, 32'h1234_5678, 32'h8765_4321, 32'h1111_1111, 32'h2222_2222, 1'b1); // R9
        run_op(3'd5, 32'h8765_4321, 32'hCAFE_F00D, 32'h0000_00FF, 32'hFF00_0000, 1'b1); // R9

        // Random mix over all codes
        for (int i = 0; i < 60; i++) begin
            run_op(3'($urandom), $urandom, $urandom, $urandom, $urandom, (i % 7) == 3);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule